// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus-write path of a parallel NOR-style flash controller model with a 16-bit word interface. Each bus write arrives as a one-clock strobe with a 20-bit address and a 16-bit data word. The decoder follows the multi-cycle command dialects: the two-write unlock prefix, the setup codes and the final operand write. When a sequence completes, it issues a single-clock request that carries an opcode, the address and the data of the final write.

The array, its timing and its supplies stay outside this block. The array side reports an embedded program in progress on `busy_i`, and the decoder drops every write that arrives while that input is high. A write that breaks a sequence discards the partial sequence without a request. A sticky pulse-program mode turns every later write into a word program. Only reset clears that mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_ni` is low, `req_valid_o` and `pulse_mode_o` are 0 and `req_op_o`, `req_addr_o`, `req_data_o` are zero. Reset asserted in the middle of a sequence discards it, so the next write is decoded from idle.
- R2: Unlock writes are compared on address bits 11:0 and data bits 7:0 only. The first unlock write is AAh at 555h. The second is 55h at AAAh, and because address bit 11 is ignored for it, 2AAh also matches. Data bits 15:8 and address bits 19:12 do not affect matching.
- R3: Unlock, then A0h at 555h, then any write gives a word-program request (opcode 1) with that write's address and data.
- R4: Unlock, 80h at 555h, unlock again, then 30h at any address gives sector erase (opcode 2) with that address. The same prefix ended by 10h at 555h gives chip erase (opcode 3).
- R5: The same six-write prefix ended by 60h at any address gives sector lockdown (opcode 4) with that address.
- R6: From idle, a single write of B0h at any address gives erase suspend (opcode 5). A single write of 30h gives erase resume (opcode 6), and its request carries the full address, so the plane sits in bits 19:18.
- R7: Unlock then 90h at 555h gives ID-mode entry (opcode 7). Unlock then F0h at 555h, or a single F0h at any address from idle, gives ID-mode exit (opcode 8).
- R8: Unlock, 80h at 555h, unlock, A0h at 555h gives pulse-mode entry (opcode 9) and sets `pulse_mode_o`. From then on, every accepted write gives a word program (opcode 1) with its own address and data, even when it carries an unlock, erase, suspend or resume code. Only reset clears the mode.
- R9: Unlock then C0h at 555h, then a write at address 080h (bits 11:0) gives protection-register lock (opcode 11). A write at any other address gives protection-register program (opcode 10). Both carry that write's address and data.
- R10: A write strobed while `busy_i` is high produces no request and leaves the sequence position unchanged.
- R11: A write that does not match the expected value for its position returns the decoder to idle without a request. From idle, any write that is neither a first unlock write nor a single-write code produces nothing.
- R12: A request is a one-clock pulse on `req_valid_o` in the clock after the accepted strobe. While no request is valid, opcode, address and data outputs are zero. Opcode 0 means no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_stb_i | input | 1 | One-clock bus-write strobe |
| addr_i | input | 20 | Write address |
| data_i | input | 16 | Write data |
| busy_i | input | 1 | Embedded program in progress; writes dropped |
| req_valid_o | output | 1 | Request pulse |
| req_op_o | output | 4 | Request opcode |
| req_addr_o | output | 20 | Address of the final write |
| req_data_o | output | 16 | Data of the final write |
| pulse_mode_o | output | 1 | Pulse-program mode active |

## Verification
The properties assume that each bus cycle reaches the block as exactly one strobe lasting one clock. They also assume that `addr_i` and `data_i` are valid in that clock. Back-to-back strobes are allowed, and the address check compares against the previous clock's inputs. The bench drives all inputs on the falling edge and raises the strobe for a single clock per write. It changes `busy_i` only together with a strobe.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int unsigned CODE_W = 8;
  localparam int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NONE       = 4'd0,
    OP_PROG       = 4'd1,
    OP_SECT_ERASE = 4'd2,
    OP_CHIP_ERASE = 4'd3,
    OP_SECT_LOCK  = 4'd4,
    OP_SUSPEND    = 4'd5,
    OP_RESUME     = 4'd6,
    OP_ID_ENTER   = 4'd7,
    OP_ID_EXIT    = 4'd8,
    OP_PULSE_ON   = 4'd9,
    OP_PREG_PROG  = 4'd10,
    OP_PREG_LOCK  = 4'd11
  } fop_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PROG,
    SQ_ERA,
    SQ_ERA_UNL1,
    SQ_ERA_UNL2,
    SQ_PREG
  } seq_e;

  typedef struct packed {
    logic              unl1;
    logic              unl2;
    logic              at_base;
    logic              at_preg_lock;
    logic [CODE_W-1:0] code;
  } wr_cls_t;

  localparam logic [CODE_W-1:0] K_UNL1    = 8'hAA;
  localparam logic [CODE_W-1:0] K_UNL2    = 8'h55;
  localparam logic [CODE_W-1:0] K_PROG    = 8'hA0;
  localparam logic [CODE_W-1:0] K_ERA     = 8'h80;
  localparam logic [CODE_W-1:0] K_SECT    = 8'h30;
  localparam logic [CODE_W-1:0] K_CHIP    = 8'h10;
  localparam logic [CODE_W-1:0] K_LOCK    = 8'h60;
  localparam logic [CODE_W-1:0] K_SUSP    = 8'hB0;
  localparam logic [CODE_W-1:0] K_RESUME  = 8'h30;
  localparam logic [CODE_W-1:0] K_ID_ON   = 8'h90;
  localparam logic [CODE_W-1:0] K_ID_OFF  = 8'hF0;
  localparam logic [CODE_W-1:0] K_PREG    = 8'hC0;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
#(
  parameter int unsigned CMP_A_W     = 12,
  parameter logic [CMP_A_W-1:0] BASE_A   = 12'h555,
  parameter logic [CMP_A_W-1:0] ALT_A    = 12'hAAA,
  parameter logic [CMP_A_W-1:0] PLOCK_A  = 12'h080,
  parameter bit  ALIAS_MSB           = 1'b1
) (
  input  logic [CMP_A_W-1:0] addr_lo_i,
  input  logic [CODE_W-1:0]  code_i,
  output wr_cls_t            cls_o
);

  logic alt_hit;

  generate
    if (ALIAS_MSB) begin : g_alias
      // top compared bit is don't-care for the second unlock address
      assign alt_hit = (addr_lo_i[CMP_A_W-2:0] == ALT_A[CMP_A_W-2:0]);
    end else begin : g_exact
      assign alt_hit = (addr_lo_i == ALT_A);
    end
  endgenerate

  always_comb begin
    cls_o.code         = code_i;
    cls_o.at_base      = (addr_lo_i == BASE_A);
    cls_o.at_preg_lock = (addr_lo_i == PLOCK_A);
    cls_o.unl1         = cls_o.at_base && (code_i == K_UNL1);
    cls_o.unl2         = alt_hit && (code_i == K_UNL2);
  end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    stb_i,
  input  wr_cls_t cls_i,
  output logic    fire_o,
  output fop_e    op_o,
  output logic    pulse_mode_o
);

  seq_e seq_q, seq_d;
  logic pulse_q, pulse_d;

  always_comb begin
    seq_d   = seq_q;
    pulse_d = pulse_q;
    fire_o  = 1'b0;
    op_o    = OP_NONE;
    if (stb_i) begin
      if (pulse_q) begin
        fire_o = 1'b1;
        op_o   = OP_PROG;
      end else begin
        seq_d = SQ_IDLE;
        unique case (seq_q)
          SQ_IDLE: begin
            if (cls_i.unl1) seq_d = SQ_UNL1;
            else begin
              unique case (cls_i.code)
                K_SUSP:   begin fire_o = 1'b1; op_o = OP_SUSPEND; end
                K_RESUME: begin fire_o = 1'b1; op_o = OP_RESUME;  end
                K_ID_OFF: begin fire_o = 1'b1; op_o = OP_ID_EXIT; end
                default: ;
              endcase
            end
          end
          SQ_UNL1: if (cls_i.unl2) seq_d = SQ_UNL2;
          SQ_UNL2: begin
            if (cls_i.at_base) begin
              unique case (cls_i.code)
                K_PROG:   seq_d = SQ_PROG;
                K_ERA:    seq_d = SQ_ERA;
                K_PREG:   seq_d = SQ_PREG;
                K_ID_ON:  begin fire_o = 1'b1; op_o = OP_ID_ENTER; end
                K_ID_OFF: begin fire_o = 1'b1; op_o = OP_ID_EXIT;  end
                default: ;
              endcase
            end
          end
          SQ_PROG: begin
            fire_o = 1'b1;
            op_o   = OP_PROG;
          end
          SQ_ERA:      if (cls_i.unl1) seq_d = SQ_ERA_UNL1;
          SQ_ERA_UNL1: if (cls_i.unl2) seq_d = SQ_ERA_UNL2;
          SQ_ERA_UNL2: begin
            unique case (cls_i.code)
              K_SECT: begin fire_o = 1'b1; op_o = OP_SECT_ERASE; end
              K_LOCK: begin fire_o = 1'b1; op_o = OP_SECT_LOCK;  end
              K_CHIP: if (cls_i.at_base) begin
                fire_o = 1'b1; op_o = OP_CHIP_ERASE;
              end
              K_PROG: if (cls_i.at_base) begin
                fire_o  = 1'b1; op_o = OP_PULSE_ON;
                pulse_d = 1'b1;
              end
              default: ;
            endcase
          end
          SQ_PREG: begin
            fire_o = 1'b1;
            op_o   = cls_i.at_preg_lock ? OP_PREG_LOCK : OP_PREG_PROG;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q   <= SQ_IDLE;
      pulse_q <= 1'b0;
    end else begin
      seq_q   <= seq_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_mode_o = pulse_q;

endmodule

// File: rtl/flash_cmd_req.sv
module flash_cmd_req
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  fop_e              op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [OP_W-1:0]   op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      op_o    <= '0;
      addr_o  <= '0;
      data_o  <= '0;
    end else if (fire_i) begin
      valid_o <= 1'b1;
      op_o    <= op_i;
      addr_o  <= addr_i;
      data_o  <= data_i;
    end else begin
      valid_o <= 1'b0;
      op_o    <= '0;
      addr_o  <= '0;
      data_o  <= '0;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CMP_A_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              busy_i,
  output logic              req_valid_o,
  output logic [OP_W-1:0]   req_op_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_data_o,
  output logic              pulse_mode_o
);

  wr_cls_t cls;
  logic    stb_ok;
  logic    fire;
  fop_e    op;

  assign stb_ok = wr_stb_i && !busy_i;

  flash_cmd_match #(
    .CMP_A_W (CMP_A_W)
  ) i_match (
    .addr_lo_i (addr_i[CMP_A_W-1:0]),
    .code_i    (data_i[CODE_W-1:0]),
    .cls_o     (cls)
  );

  flash_cmd_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stb_i        (stb_ok),
    .cls_i        (cls),
    .fire_o       (fire),
    .op_o         (op),
    .pulse_mode_o (pulse_mode_o)
  );

  flash_cmd_req #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .op_i    (op),
    .addr_i  (addr_i),
    .data_i  (data_i),
    .valid_o (req_valid_o),
    .op_o    (req_op_o),
    .addr_o  (req_addr_o),
    .data_o  (req_data_o)
  );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_stb_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] data_i,
  input logic              busy_i,
  input logic              req_valid_o,
  input logic [OP_W-1:0]   req_op_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [DATA_W-1:0] req_data_o,
  input logic              pulse_mode_o
);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!req_valid_o && !pulse_mode_o && req_op_o == '0);
    end
  end

  p_req_needs_stb_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> !req_valid_o);

  p_idle_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_o |-> (req_op_o == '0 && req_addr_o == '0 && req_data_o == '0));

  p_valid_has_op_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_op_o != OP_NONE);

  p_busy_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && busy_i) |=> !req_valid_o);

  p_carry_operand_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && !busy_i) |=> (!req_valid_o ||
      (req_addr_o == $past(addr_i) && req_data_o == $past(data_i))));

  p_pulse_prog_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_mode_o && wr_stb_i && !busy_i) |=> (req_valid_o && req_op_o == OP_PROG));

  p_pulse_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_mode_o |=> pulse_mode_o);

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_stb_i     (wr_stb_i),
  .addr_i       (addr_i),
  .data_i       (data_i),
  .busy_i       (busy_i),
  .req_valid_o  (req_valid_o),
  .req_op_o     (req_op_o),
  .req_addr_o   (req_addr_o),
  .req_data_o   (req_data_o),
  .pulse_mode_o (pulse_mode_o)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

  localparam logic [3:0] ON = 4'd0, OPG = 4'd1, OSE = 4'd2, OCE = 4'd3,
                         OSL = 4'd4, OSU = 4'd5, ORS = 4'd6, OIE = 4'd7,
                         OIX = 4'd8, OPM = 4'd9, OPP = 4'd10, OPL = 4'd11;

  typedef struct packed {
    logic [19:0] a;
    logic [15:0] d;
    logic        bsy;
    logic        ev;
    logic [3:0]  op;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 63;
  localparam vec_t VEC [NV] = '{
    // R3 word program
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, ON,  4'd3},
    '{20'h00AAA, 16'h0055, 1'b0, 1'b0, ON,  4'd3},
    '{20'h00555, 16'h00A0, 1'b0, 1'b0, ON,  4'd3},
    '{20'h12345, 16'hBEEF, 1'b0, 1'b1, OPG, 4'd3},
    // R2 upper bits ignored, 2AA alias
    '{20'hF1555, 16'h12AA, 1'b0, 1'b0, ON,  4'd2},
    '{20'h3A2AA, 16'hFF55, 1'b0, 1'b0, ON,  4'd2},
    '{20'h00555, 16'h77A0, 1'b0, 1'b0, ON,  4'd2},
    '{20'h00010, 16'h0000, 1'b0, 1'b1, OPG, 4'd2},
    // R4 sector erase
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, ON,  4'd4},
    '{20'h00AAA, 16'h0055, 1'b0, 1'b0, ON,  4'd4},
    '{20'h00555, 16'h0080, 1'b0, 1'b0, ON,  4'd4},
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, ON,  4'd4},
    '{20'h002AA, 16'h0055, 1'b0, 1'b0, ON,  4'd4},
    '{20'h40010, 16'h0030, 1'b0, 1'b1, OSE, 4'd4},
    // R4 chip erase
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, ON,  4'd4},
    '{20'h00AAA, 16'h0055, 1'b0, 1'b0, ON,  4'd4},
    '{20'h00555, 16'h0080, 1'b0, 1'b0, ON,  4'd4},
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, ON,  4'd4},
    '{20'h00AAA, 16'h0055, 1'b0, 1'b0, ON,  4'd4},
    '{20'h00555, 16'h0010, 1'b0, 1'b1, OCE, 4'd4},
    // R5 sector lockdown
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, ON,  4'd5},
    '{20'h00AAA, 16'h0055, 1'b0, 1'b0, ON,  4'd5},
    '{20'h00555, 16'h0080, 1'b0, 1'b0, ON,  4'd5},
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, ON,  4'd5},
    '{20'h00AAA, 16'h0055, 1'b0, 1'b0, ON,  4'd5},
    '{20'h80000, 16'h0060, 1'b0, 1'b1, OSL, 4'd5},
    // R6 suspend / resume
    '{20'h12345, 16'h00B0, 1'b0, 1'b1, OSU, 4'd6},
    '{20'hC0000, 16'h0030, 1'b0, 1'b1, ORS, 4'd6},
    // R7 id entry / exits
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, ON,  4'd7},
    '{20'h00AAA, 16'h0055, 1'b0, 1'b0, ON,  4'd7},
    '{20'h00555, 16'h0090, 1'b0, 1'b1, OIE, 4'd7},
    '{20'h00000, 16'h00F0, 1'b0, 1'b1, OIX, 4'd7},
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, ON,  4'd7},
    '{20'h00AAA, 16'h0055, 1'b0, 1'b0, ON,  4'd7},
    '{20'h00555, 16'h00F0, 1'b0, 1'b1, OIX, 4'd7},
    // R9 protection register program / lock
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, ON,  4'd9},
    '{20'h00AAA, 16'h0055, 1'b0, 1'b0, ON,  4'd9},
    '{20'h00555, 16'h00C0, 1'b0, 1'b0, ON,  4'd9},
    '{20'h00081, 16'h1234, 1'b0, 1'b1, OPP, 4'd9},
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, ON,  4'd9},
    '{20'h00AAA, 16'h0055, 1'b0, 1'b0, ON,  4'd9},
    '{20'h00555, 16'h00C0, 1'b0, 1'b0, ON,  4'd9},
    '{20'h00080, 16'hFFFD, 1'b0, 1'b1, OPL, 4'd9},
    // R10 busy writes dropped, sequence kept
    '{20'h12345, 16'h00B0, 1'b1, 1'b0, ON,  4'd10},
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, ON,  4'd10},
    '{20'h00000, 16'h1234, 1'b1, 1'b0, ON,  4'd10},
    '{20'h00AAA, 16'h0055, 1'b0, 1'b0, ON,  4'd10},
    '{20'h00555, 16'h00A0, 1'b0, 1'b0, ON,  4'd10},
    '{20'h00100, 16'h5555, 1'b0, 1'b1, OPG, 4'd10},
    // R11 bad cycles abort
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, ON,  4'd11},
    '{20'h00AAA, 16'h0056, 1'b0, 1'b0, ON,  4'd11},
    '{20'h00555, 16'h00A0, 1'b0, 1'b0, ON,  4'd11},
    '{20'h00200, 16'h1111, 1'b0, 1'b0, ON,  4'd11},
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, ON,  4'd11},
    '{20'h00555, 16'h0055, 1'b0, 1'b0, ON,  4'd11},
    '{20'h00AAA, 16'h0055, 1'b0, 1'b0, ON,  4'd11},
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, ON,  4'd11},
    '{20'h00AAA, 16'h0055, 1'b0, 1'b0, ON,  4'd11},
    '{20'h00555, 16'h0080, 1'b0, 1'b0, ON,  4'd11},
    '{20'h00555, 16'h00AA, 1'b0, 1'b0, ON,  4'd11},
    '{20'h00AAA, 16'h0055, 1'b0, 1'b0, ON,  4'd11},
    '{20'h00555, 16'h0020, 1'b0, 1'b0, ON,  4'd11},
    '{20'h40000, 16'h0030, 1'b0, 1'b1, ORS, 4'd11}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_stb_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic [15:0] data_i = '0;
  logic        busy_i = 1'b0;
  logic        req_valid_o;
  logic [3:0]  req_op_o;
  logic [19:0] req_addr_o;
  logic [15:0] req_data_o;
  logic        pulse_mode_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_stb_i     (wr_stb_i),
    .addr_i       (addr_i),
    .data_i       (data_i),
    .busy_i       (busy_i),
    .req_valid_o  (req_valid_o),
    .req_op_o     (req_op_o),
    .req_addr_o   (req_addr_o),
    .req_data_o   (req_data_o),
    .pulse_mode_o (pulse_mode_o)
  );

  task automatic wr(input logic [19:0] a, input logic [15:0] d, input logic b);
    @(negedge clk_i);
    wr_stb_i = 1'b1;
    addr_i   = a;
    data_i   = d;
    busy_i   = b;
    @(negedge clk_i);
    wr_stb_i = 1'b0;
    busy_i   = 1'b0;
  endtask

  task automatic chk_req(input string rq, input logic ev, input logic [3:0] op,
                         input logic [19:0] a, input logic [15:0] d);
    logic [40:0] got, exp;
    got = {req_valid_o, req_op_o, req_addr_o, req_data_o};
    exp = ev ? {1'b1, op, a, d} : 41'd0;
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got v=%b op=%0d a=%h d=%h exp v=%b op=%0d a=%h d=%h", rq,
               got[40], got[39:36], got[35:16], got[15:0],
               exp[40], exp[39:36], exp[35:16], exp[15:0]);
    end
  endtask

  task automatic chk_bit(input string rq, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b exp %b", rq, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk_req("R1 reset outputs", 1'b0, ON, '0, '0);
    chk_bit("R1 reset pulse mode", pulse_mode_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles exp < 20000", cycles);
      finish_run();
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk_i);
    chk_req("R1 in reset", 1'b0, ON, '0, '0);
    chk_bit("R1 in reset pulse", pulse_mode_o, 1'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].a, VEC[i].d, VEC[i].bsy);
      chk_req($sformatf("R%0d vec %0d", VEC[i].rq, i), VEC[i].ev, VEC[i].op,
              VEC[i].a, VEC[i].d);
    end

    // R12 no strobe, no request
    @(negedge clk_i);
    chk_req("R12 idle", 1'b0, ON, '0, '0);

    // R1 reset aborts a partial sequence
    wr(20'h00555, 16'h00AA, 1'b0);
    wr(20'h00AAA, 16'h0055, 1'b0);
    do_reset();
    wr(20'h00555, 16'h00A0, 1'b0);
    chk_req("R1 abort step", 1'b0, ON, '0, '0);
    wr(20'h00300, 16'h0001, 1'b0);
    chk_req("R1 abort no prog", 1'b0, ON, '0, '0);

    // R8 pulse mode
    wr(20'h00555, 16'h00AA, 1'b0);
    wr(20'h00AAA, 16'h0055, 1'b0);
    wr(20'h00555, 16'h0080, 1'b0);
    wr(20'h00555, 16'h00AA, 1'b0);
    wr(20'h00AAA, 16'h0055, 1'b0);
    wr(20'h00555, 16'h00A0, 1'b0);
    chk_req("R8 entry", 1'b1, OPM, 20'h00555, 16'h00A0);
    chk_bit("R8 mode set", pulse_mode_o, 1'b1);
    wr(20'h00555, 16'h00AA, 1'b0);
    chk_req("R8 unlock as prog", 1'b1, OPG, 20'h00555, 16'h00AA);
    wr(20'h54321, 16'h00B0, 1'b0);
    chk_req("R8 suspend as prog", 1'b1, OPG, 20'h54321, 16'h00B0);
    wr(20'h40000, 16'h0030, 1'b0);
    chk_req("R8 resume as prog", 1'b1, OPG, 20'h40000, 16'h0030);
    wr(20'h00777, 16'hCAFE, 1'b1);
    chk_req("R10 busy in pulse mode", 1'b0, ON, '0, '0);
    chk_bit("R8 mode stays", pulse_mode_o, 1'b1);
    wr(20'hFFFFF, 16'hFFFF, 1'b0);
    chk_req("R8 plain prog", 1'b1, OPG, 20'hFFFFF, 16'hFFFF);
    do_reset();
    chk_bit("R8 cleared by reset", pulse_mode_o, 1'b0);
    wr(20'h54321, 16'h00B0, 1'b0);
    chk_req("R6 suspend after reset", 1'b1, OSU, 20'h54321, 16'h00B0);

    // R4 chip erase needs base address
    wr(20'h00555, 16'h00AA, 1'b0);
    wr(20'h00AAA, 16'h0055, 1'b0);
    wr(20'h00555, 16'h0080, 1'b0);
    wr(20'h00555, 16'h00AA, 1'b0);
    wr(20'h00AAA, 16'h0055, 1'b0);
    wr(20'h00556, 16'h0010, 1'b0);
    chk_req("R4 chip erase off base", 1'b0, ON, '0, '0);

    finish_run();
  end

endmodule